// File: doc/BRIEF.md
# Synchronous Exception Trap Entry Unit

This block performs trap entry for a synchronous exception in a 64-bit processor core, and it does so in a single clock cycle. The core presents an exception kind together with the program counter of the faulting instruction and one word of extra information. The extra word is the faulting address for page faults and the instruction bits for an illegal instruction. In the cycle the strobe is high, the block turns the kind into an architectural cause number. It chooses the return address to save and the trap value to record. It then sends the trap either to supervisor or to machine level.

At the chosen level the block records the return address, cause and trap value. It pushes that level's interrupt enable into its "previous" slot and records the privilege the trap came from. It switches the privilege mode and presents the handler address taken from that level's vector register. A two-bit class tells the core whether the trap is fatal, transparent to software, or an explicit request from software.

A small register port lets software or a test environment load the vector registers, the delegation mask, the status word and the current privilege. A read port with a combinational path returns the state.

Top module: `trap_entry_unit`

## Requirements
- R1: The kind input is encoded as 0 instr-misaligned, 1 instr-access, 2 illegal, 3 breakpoint, 4 load-misaligned, 5 load-access, 6 store-misaligned, 7 store-access, 8 ecall-U, 9 ecall-S, 10 ecall-M, 11 instr-page, 12 load-page, 13 store-page. Kinds 0 to 9 keep their number as cause, and kinds 10, 11, 12 and 13 map to causes 11, 12, 13 and 15. No trap ever records cause 10 or 14.
- R2: The saved exception PC equals the input PC for breakpoint, the three environment calls and the three page faults. For every other kind it equals the input PC plus 4, modulo 2^64.
- R3: The trap value is the saved exception PC for the misaligned, access-fault and breakpoint kinds. It is the info input for page faults and for an illegal instruction, and zero for environment calls.
- R4: Privilege is encoded U=0, S=1, M=3. A trap goes to supervisor level only when the current privilege is U or S and bit [cause] of the delegation mask is 1. In every other case it goes to machine level.
- R5: A supervisor-level trap sets privilege S and presents a handler PC equal to the supervisor vector with bit 0 cleared. It writes the supervisor EPC (input saved PC with bit 0 cleared), the supervisor cause and the supervisor trap value.
- R6: A supervisor-level trap copies status bit 1 into status bit 5 and clears bit 1. It sets status bit 8 to 0 when the trap came from U and to 1 otherwise.
- R7: A machine-level trap sets privilege M and presents the machine vector with bit 0 cleared. It writes the machine EPC (bit 0 cleared), the machine cause and the machine trap value.
- R8: A machine-level trap copies status bit 3 into status bit 7 and clears bit 3. It writes the previous privilege code into status bits 12:11.
- R9: The class output is 3 (fatal) for misaligned and access-fault kinds, 2 (invisible) for illegal instruction and page faults, and 1 (requested) for breakpoint and environment calls.
- R10: A strobe with kind 14 or 15, or a software write of the value 2 to the privilege register, raises the error output one cycle later. It causes no trap and changes no state.
- R11: Reset sets privilege M and clears every register, with trap_done and the error output low. The addresses are 0x300 status (writable bits 1,3,5,7,8,12:11), 0x302 delegation mask, 0x305/0x341/0x342/0x343 machine vector/EPC/cause/trap value, 0x105/0x141/0x142/0x143 the supervisor equivalents, and 0x7C0 privilege.
- R12: A software write in the same cycle as an accepted trap is discarded.
- R13: Bit 11 of the delegation mask always reads 0, so an ecall from M can never be delegated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception strobe |
| exc_kind | input | 4 | Exception kind code (R1) |
| exc_pc | input | 64 | PC of the excepting instruction |
| exc_info | input | 64 | Faulting address or instruction bits |
| wr_en | input | 1 | Software register write strobe |
| wr_addr | input | 12 | Software write address |
| wr_data | input | 64 | Software write data |
| rd_addr | input | 12 | Read address |
| rd_data | output | 64 | Read data, combinational |
| trap_done | output | 1 | Pulses the cycle after a trap is taken |
| priv_mode | output | 2 | Current privilege mode |
| handler_pc | output | 64 | Handler address of the last trap |
| trap_class | output | 2 | Class of the last trap |
| req_err | output | 1 | Pulses after a rejected request |

## Verification
An accepted trap and a software register write can land in the same cycle, and both target the same register file. The bench raises the strobe together with writes to the delegation mask and to the machine trap-value register. It then reads both back. The delegation mask must hold its old value, and the trap value must be the one the trap produced, not the one software wrote.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   typedef enum logic [1:0] {
      PRV_U    = 2'd0,
      PRV_S    = 2'd1,
      PRV_RSVD = 2'd2,
      PRV_M    = 2'd3
   } prv_e;

   typedef enum logic [1:0] {
      TC_CONTAINED = 2'd0,
      TC_REQUESTED = 2'd1,
      TC_INVISIBLE = 2'd2,
      TC_FATAL     = 2'd3
   } tclass_e;

   typedef enum logic [3:0] {
      EK_IMIS  = 4'd0,
      EK_IACC  = 4'd1,
      EK_ILL   = 4'd2,
      EK_BRK   = 4'd3,
      EK_LMIS  = 4'd4,
      EK_LACC  = 4'd5,
      EK_SMIS  = 4'd6,
      EK_SACC  = 4'd7,
      EK_ECU   = 4'd8,
      EK_ECS   = 4'd9,
      EK_ECM   = 4'd10,
      EK_IPF   = 4'd11,
      EK_LPF   = 4'd12,
      EK_SPF   = 4'd13
   } ekind_e;

   localparam int KIND_LAST      = 13;
   localparam int CAUSE_ECALL_M  = 11;

   // register addresses (12-bit space)
   localparam logic [11:0] ADR_STATUS = 12'h300;
   localparam logic [11:0] ADR_DELEG  = 12'h302;
   localparam logic [11:0] ADR_PRIV   = 12'h7C0;
   localparam logic [11:0] OFS_VEC    = 12'h005;
   localparam logic [11:0] OFS_EPC    = 12'h041;
   localparam logic [11:0] OFS_CAUSE  = 12'h042;
   localparam logic [11:0] OFS_TVAL   = 12'h043;

   // trap levels held in the register bank
   localparam int NLVL   = 2;
   localparam int LVL_S  = 0;
   localparam int LVL_M  = 1;

   // status bit positions
   localparam int ST_SIE  = 1;
   localparam int ST_MIE  = 3;
   localparam int ST_SPIE = 5;
   localparam int ST_MPIE = 7;
   localparam int ST_SPP  = 8;
   localparam int ST_MPP  = 11;

   function automatic logic [11:0] lvl_base(input int lvl);
      return (lvl == LVL_S) ? 12'h100 : 12'h300;
   endfunction

endpackage

// File: rtl/trap_cause_decode.sv
module trap_cause_decode
   import trap_entry_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int KIND_W  = 4,
   parameter int CAUSE_W = 4
) (
   input  logic [KIND_W-1:0]  kind,
   input  logic [XLEN-1:0]    pc,
   input  logic [XLEN-1:0]    info,
   output logic               kind_ok,
   output logic [CAUSE_W-1:0] cause,
   output logic [XLEN-1:0]    epc,
   output logic [XLEN-1:0]    tval,
   output tclass_e            tclass
);

   localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

   typedef enum logic [1:0] {
      TV_ZERO = 2'd0,
      TV_EPC  = 2'd1,
      TV_INFO = 2'd2
   } tv_src_e;

   logic     keep_pc;
   tv_src_e  tv_src;
   logic [XLEN-1:0] pc_next;

   initial begin
      assert (KIND_W >= 4) else $error("KIND_W too narrow for kind codes");
      assert (CAUSE_W >= 4) else $error("CAUSE_W too narrow for cause codes");
      assert (XLEN >= 16) else $error("XLEN too narrow");
   end

   assign pc_next = pc + INSN_BYTES;

   always_comb begin
      kind_ok = 1'b1;
      cause   = '0;
      keep_pc = 1'b0;
      tv_src  = TV_ZERO;
      tclass  = TC_FATAL;
      if (kind > KIND_W'(KIND_LAST)) begin
         kind_ok = 1'b0;
      end else begin
         case (ekind_e'(kind[3:0]))
            EK_IMIS: begin cause = CAUSE_W'(0);  tv_src = TV_EPC;  tclass = TC_FATAL; end
            EK_IACC: begin cause = CAUSE_W'(1);  tv_src = TV_EPC;  tclass = TC_FATAL; end
            EK_ILL:  begin cause = CAUSE_W'(2);  tv_src = TV_INFO; tclass = TC_INVISIBLE; end
            EK_BRK:  begin cause = CAUSE_W'(3);  tv_src = TV_EPC;  tclass = TC_REQUESTED; keep_pc = 1'b1; end
            EK_LMIS: begin cause = CAUSE_W'(4);  tv_src = TV_EPC;  tclass = TC_FATAL; end
            EK_LACC: begin cause = CAUSE_W'(5);  tv_src = TV_EPC;  tclass = TC_FATAL; end
            EK_SMIS: begin cause = CAUSE_W'(6);  tv_src = TV_EPC;  tclass = TC_FATAL; end
            EK_SACC: begin cause = CAUSE_W'(7);  tv_src = TV_EPC;  tclass = TC_FATAL; end
            EK_ECU:  begin cause = CAUSE_W'(8);  tv_src = TV_ZERO; tclass = TC_REQUESTED; keep_pc = 1'b1; end
            EK_ECS:  begin cause = CAUSE_W'(9);  tv_src = TV_ZERO; tclass = TC_REQUESTED; keep_pc = 1'b1; end
            EK_ECM:  begin cause = CAUSE_W'(11); tv_src = TV_ZERO; tclass = TC_REQUESTED; keep_pc = 1'b1; end
            EK_IPF:  begin cause = CAUSE_W'(12); tv_src = TV_INFO; tclass = TC_INVISIBLE; keep_pc = 1'b1; end
            EK_LPF:  begin cause = CAUSE_W'(13); tv_src = TV_INFO; tclass = TC_INVISIBLE; keep_pc = 1'b1; end
            EK_SPF:  begin cause = CAUSE_W'(15); tv_src = TV_INFO; tclass = TC_INVISIBLE; keep_pc = 1'b1; end
            default: kind_ok = 1'b0;
         endcase
      end
   end

   assign epc = keep_pc ? pc : pc_next;

   always_comb begin
      case (tv_src)
         TV_EPC:  tval = epc;
         TV_INFO: tval = info;
         default: tval = '0;
      endcase
   end

endmodule

// File: rtl/trap_route.sv
module trap_route
   import trap_entry_pkg::*;
#(
   parameter int NUM_CAUSE = 16,
   parameter int CAUSE_W   = 4
) (
   input  prv_e                 cur_mode,
   input  logic [CAUSE_W-1:0]   cause,
   input  logic [NUM_CAUSE-1:0] edeleg,
   output logic                 mode_ok,
   output logic                 to_super
);

   logic below_m;
   logic sel_bit;

   initial begin
      assert (NUM_CAUSE == (1 << CAUSE_W)) else $error("NUM_CAUSE must be 2**CAUSE_W");
   end

   assign mode_ok  = (cur_mode != PRV_RSVD);
   assign below_m  = (cur_mode == PRV_U) || (cur_mode == PRV_S);
   assign sel_bit  = edeleg[cause];
   assign to_super = below_m && sel_bit;

endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
   import trap_entry_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int ADDR_W    = 12,
   parameter int NUM_CAUSE = 16,
   parameter int CAUSE_W   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trap_fire,
   input  logic                 to_super,
   input  logic [CAUSE_W-1:0]   cause,
   input  logic [XLEN-1:0]      epc,
   input  logic [XLEN-1:0]      tval,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [XLEN-1:0]      wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [XLEN-1:0]      rd_data,
   output prv_e                 mode,
   output logic [NUM_CAUSE-1:0] edeleg,
   output logic [XLEN-1:0]      svec,
   output logic [XLEN-1:0]      mvec,
   output logic [XLEN-1:0]      status,
   output logic                 mode_wr_bad
);

   localparam logic [XLEN-1:0] ST_WMASK =
      (XLEN'(1) << ST_SIE)  | (XLEN'(1) << ST_MIE)  |
      (XLEN'(1) << ST_SPIE) | (XLEN'(1) << ST_MPIE) |
      (XLEN'(1) << ST_SPP)  | (XLEN'(3) << ST_MPP);
   localparam logic [NUM_CAUSE-1:0] DELEG_WMASK =
      ~(NUM_CAUSE'(1) << CAUSE_ECALL_M);
   localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADR_STATUS);
   localparam logic [ADDR_W-1:0] A_DELEG  = ADDR_W'(ADR_DELEG);
   localparam logic [ADDR_W-1:0] A_PRIV   = ADDR_W'(ADR_PRIV);

   logic                 sw_ok;
   prv_e                 mode_q;
   logic [NUM_CAUSE-1:0] edeleg_q;
   logic [XLEN-1:0]      status_q;
   logic [XLEN-1:0]      rd_part [NLVL];
   logic [XLEN-1:0]      lvl_vec [NLVL];

   initial begin
      assert (ADDR_W >= 12) else $error("ADDR_W must cover the 12-bit map");
      assert (XLEN > ST_MPP + 1) else $error("XLEN must hold the status word");
      assert (NUM_CAUSE > CAUSE_ECALL_M) else $error("NUM_CAUSE too small");
   end

   assign sw_ok = wr_en && !trap_fire;

   // per-level trap state: vector, saved PC, cause, trap value
   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      localparam logic [ADDR_W-1:0] A_VEC   = ADDR_W'(lvl_base(l) | OFS_VEC);
      localparam logic [ADDR_W-1:0] A_EPC   = ADDR_W'(lvl_base(l) | OFS_EPC);
      localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(lvl_base(l) | OFS_CAUSE);
      localparam logic [ADDR_W-1:0] A_TVAL  = ADDR_W'(lvl_base(l) | OFS_TVAL);
      localparam logic              IS_SUP  = (l == LVL_S);

      logic [XLEN-1:0] vec_q;
      logic [XLEN-1:0] epc_q;
      logic [XLEN-1:0] cause_q;
      logic [XLEN-1:0] tval_q;
      logic            hit;

      assign hit = trap_fire && (to_super == IS_SUP);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vec_q   <= '0;
            epc_q   <= '0;
            cause_q <= '0;
            tval_q  <= '0;
         end else if (hit) begin
            epc_q   <= epc & EVEN_MASK;
            cause_q <= XLEN'(cause);
            tval_q  <= tval;
         end else if (sw_ok) begin
            if (wr_addr == A_VEC)   vec_q   <= wr_data;
            if (wr_addr == A_EPC)   epc_q   <= wr_data;
            if (wr_addr == A_CAUSE) cause_q <= wr_data;
            if (wr_addr == A_TVAL)  tval_q  <= wr_data;
         end
      end

      always_comb begin
         rd_part[l] = '0;
         if (rd_addr == A_VEC)   rd_part[l] = vec_q;
         if (rd_addr == A_EPC)   rd_part[l] = epc_q;
         if (rd_addr == A_CAUSE) rd_part[l] = cause_q;
         if (rd_addr == A_TVAL)  rd_part[l] = tval_q;
      end

      assign lvl_vec[l] = vec_q;
   end

   assign mode_wr_bad = sw_ok && (wr_addr == A_PRIV) && (wr_data[1:0] == PRV_RSVD);

   // privilege, delegation mask and status word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= PRV_M;
         edeleg_q <= '0;
         status_q <= '0;
      end else if (trap_fire) begin
         if (to_super) begin
            mode_q            <= PRV_S;
            status_q[ST_SPIE] <= status_q[ST_SIE];
            status_q[ST_SIE]  <= 1'b0;
            status_q[ST_SPP]  <= (mode_q != PRV_U);
         end else begin
            mode_q                    <= PRV_M;
            status_q[ST_MPIE]         <= status_q[ST_MIE];
            status_q[ST_MIE]          <= 1'b0;
            status_q[ST_MPP+1:ST_MPP] <= mode_q;
         end
      end else if (sw_ok) begin
         if (wr_addr == A_STATUS) status_q <= wr_data & ST_WMASK;
         if (wr_addr == A_DELEG)  edeleg_q <= wr_data[NUM_CAUSE-1:0] & DELEG_WMASK;
         if ((wr_addr == A_PRIV) && !mode_wr_bad) mode_q <= prv_e'(wr_data[1:0]);
      end
   end

   always_comb begin
      rd_data = '0;
      for (int l = 0; l < NLVL; l++) rd_data = rd_data | rd_part[l];
      if (rd_addr == A_STATUS) rd_data = rd_data | status_q;
      if (rd_addr == A_DELEG)  rd_data = rd_data | XLEN'(edeleg_q);
      if (rd_addr == A_PRIV)   rd_data = rd_data | XLEN'(mode_q);
   end

   assign mode   = mode_q;
   assign edeleg = edeleg_q;
   assign status = status_q;
   assign svec   = lvl_vec[LVL_S];
   assign mvec   = lvl_vec[LVL_M];

   AST_DELEG_B11_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      edeleg_q[CAUSE_ECALL_M] == 1'b0); // R13

   AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && wr_en && wr_addr == A_DELEG) |=> $stable(edeleg_q)); // R12

   AST_BAD_PRIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr_bad |=> $stable(mode_q)); // R10

   AST_SPP_FROM_U: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && to_super && mode_q == PRV_U) |=> !status_q[ST_SPP]); // R6

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_entry_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int ADDR_W    = 12,
   parameter int KIND_W    = 4,
   parameter int CAUSE_W   = 4,
   parameter int NUM_CAUSE = 1 << CAUSE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_valid,
   input  logic [KIND_W-1:0] exc_kind,
   input  logic [XLEN-1:0]   exc_pc,
   input  logic [XLEN-1:0]   exc_info,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [XLEN-1:0]   wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [XLEN-1:0]   rd_data,
   output logic              trap_done,
   output logic [1:0]        priv_mode,
   output logic [XLEN-1:0]   handler_pc,
   output logic [1:0]        trap_class,
   output logic              req_err
);

   localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);

   logic                 kind_ok;
   logic [CAUSE_W-1:0]   cause;
   logic [XLEN-1:0]      epc;
   logic [XLEN-1:0]      tval;
   tclass_e              tclass;
   prv_e                 mode;
   logic [NUM_CAUSE-1:0] edeleg;
   logic [XLEN-1:0]      svec;
   logic [XLEN-1:0]      mvec;
   logic [XLEN-1:0]      status;
   logic                 mode_ok;
   logic                 to_super;
   logic                 mode_wr_bad;
   logic                 trap_fire;
   logic                 bad_req;

   logic                 done_q;
   logic                 err_q;
   logic [XLEN-1:0]      hpc_q;
   tclass_e              class_q;

   initial begin
      assert (NUM_CAUSE == (1 << CAUSE_W)) else $error("cause space mismatch");
   end

   trap_cause_decode #(
      .XLEN(XLEN), .KIND_W(KIND_W), .CAUSE_W(CAUSE_W)
   ) u_dec (
      .kind(exc_kind), .pc(exc_pc), .info(exc_info),
      .kind_ok(kind_ok), .cause(cause), .epc(epc), .tval(tval), .tclass(tclass)
   );

   trap_route #(
      .NUM_CAUSE(NUM_CAUSE), .CAUSE_W(CAUSE_W)
   ) u_route (
      .cur_mode(mode), .cause(cause), .edeleg(edeleg),
      .mode_ok(mode_ok), .to_super(to_super)
   );

   assign trap_fire = exc_valid && kind_ok && mode_ok;
   assign bad_req   = (exc_valid && !(kind_ok && mode_ok)) || mode_wr_bad;

   trap_csr_bank #(
      .XLEN(XLEN), .ADDR_W(ADDR_W), .NUM_CAUSE(NUM_CAUSE), .CAUSE_W(CAUSE_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .trap_fire(trap_fire), .to_super(to_super), .cause(cause),
      .epc(epc), .tval(tval),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .mode(mode), .edeleg(edeleg), .svec(svec), .mvec(mvec),
      .status(status), .mode_wr_bad(mode_wr_bad)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         hpc_q   <= '0;
         class_q <= TC_CONTAINED;
      end else begin
         done_q <= trap_fire;
         err_q  <= bad_req;
         if (trap_fire) begin
            hpc_q   <= (to_super ? svec : mvec) & EVEN_MASK;
            class_q <= tclass;
         end
      end
   end

   assign trap_done  = done_q;
   assign req_err    = err_q;
   assign handler_pc = hpc_q;
   assign trap_class = class_q;
   assign priv_mode  = mode;

   AST_SUPER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && to_super) |=> (priv_mode == PRV_S)); // R5

   AST_MACH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && !to_super) |=> (priv_mode == PRV_M)); // R7

   AST_MIE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && !to_super) |=> !status[ST_MIE]); // R8

   AST_SIE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire && to_super) |=> !status[ST_SIE]); // R6

   AST_M_NOT_DELEGATED: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && priv_mode == PRV_M) |-> !to_super); // R4

   AST_NO_RSVD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire |-> (cause != CAUSE_W'(10) && cause != CAUSE_W'(14))); // R1

   AST_BAD_KIND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && !kind_ok) |=> ($stable(priv_mode) && !trap_done && req_err)); // R10

   AST_HANDLER_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      trap_done |-> !handler_pc[0]); // R5

endmodule

// File: tb/sim_trap_entry_unit.sv
module sim_trap_entry_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        exc_valid;
   logic [3:0]  exc_kind;
   logic [63:0] exc_pc, exc_info;
   logic        wr_en;
   logic [11:0] wr_addr, rd_addr;
   logic [63:0] wr_data, rd_data;
   logic        trap_done, req_err;
   logic [1:0]  priv_mode, trap_class;
   logic [63:0] handler_pc;

   always #5 clk = ~clk;

   trap_entry_unit u0 (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_kind(exc_kind),
      .exc_pc(exc_pc), .exc_info(exc_info), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .trap_done(trap_done), .priv_mode(priv_mode), .handler_pc(handler_pc),
      .trap_class(trap_class), .req_err(req_err)
   );

   typedef struct {
      logic [63:0] hpc;
      logic [1:0]  cls;
      logic [1:0]  mode;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done_flag = 0;

   // bench model of the architectural state
   logic [1:0]  m_mode;
   logic [63:0] m_stat, m_deleg;
   logic [63:0] m_vec[2], m_epc[2], m_cause[2], m_tval[2];   // 0 = S, 1 = M

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   function automatic logic [3:0] f_cause(input logic [3:0] k);
      case (k)
         4'd10: return 4'd11;
         4'd11: return 4'd12;
         4'd12: return 4'd13;
         4'd13: return 4'd15;
         default: return k;
      endcase
   endfunction

   function automatic bit f_keep_pc(input logic [3:0] k);
      return (k == 3) || (k >= 8 && k <= 13);
   endfunction

   function automatic logic [1:0] f_class(input logic [3:0] k);
      if (k == 2 || k >= 11) return 2'd2;
      if (k == 3 || (k >= 8 && k <= 10)) return 2'd1;
      return 2'd3;
   endfunction

   function automatic logic [11:0] f_adr(input int lvl, input logic [11:0] ofs);
      return (lvl == 0 ? 12'h100 : 12'h300) | ofs;
   endfunction

   task automatic sw_write(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         12'h300: m_stat  = d & 64'h19AA;
         12'h302: m_deleg = d & 64'hF7FF;
         12'h7C0: if (d[1:0] != 2'd2) m_mode = d[1:0];
         12'h105: m_vec[0] = d;
         12'h305: m_vec[1] = d;
         default: ;
      endcase
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [63:0] exp);
      @(negedge clk);
      rd_addr = a;
      #1;
      chk(req, $sformatf("reg %h", a), rd_data, exp);
   endtask

   // driver: applies one exception, predicts the result, pushes it to the scoreboard
   task automatic do_trap(input string req, input logic [3:0] k, input logic [63:0] pc,
                          input logic [63:0] info, input bit w = 0,
                          input logic [11:0] wa = '0, input logic [63:0] wd = '0);
      logic [3:0]  c;
      logic [63:0] e, tv;
      int          lvl;
      exp_t        x;
      c   = f_cause(k);
      e   = f_keep_pc(k) ? pc : pc + 64'd4;
      if (k == 2 || k >= 11)              tv = info;
      else if (k >= 8)                    tv = '0;
      else                                tv = e;
      lvl = ((m_mode == 2'd0 || m_mode == 2'd1) && m_deleg[c]) ? 0 : 1;
      m_epc[lvl]   = e & ~64'd1;
      m_cause[lvl] = 64'(c);
      m_tval[lvl]  = tv;
      if (lvl == 0) begin
         m_stat[5] = m_stat[1];
         m_stat[1] = 1'b0;
         m_stat[8] = (m_mode != 2'd0);
      end else begin
         m_stat[7]     = m_stat[3];
         m_stat[3]     = 1'b0;
         m_stat[12:11] = m_mode;
      end
      m_mode = (lvl == 0) ? 2'd1 : 2'd3;
      x.hpc  = m_vec[lvl] & ~64'd1;
      x.cls  = f_class(k);
      x.mode = m_mode;
      x.req  = req;
      @(negedge clk);
      exp_q.push_back(x);
      exc_valid = 1'b1; exc_kind = k; exc_pc = pc; exc_info = info;
      wr_en = w; wr_addr = wa; wr_data = wd;
      @(negedge clk);
      exc_valid = 1'b0; wr_en = 1'b0;
   endtask

   task automatic chk_level(input string req, input int lvl);
      rd_chk(req, f_adr(lvl, 12'h041), m_epc[lvl]);
      rd_chk(req, f_adr(lvl, 12'h042), m_cause[lvl]);
      rd_chk(req, f_adr(lvl, 12'h043), m_tval[lvl]);
      rd_chk(req, 12'h300, m_stat);
      rd_chk(req, 12'h7C0, 64'(m_mode));
   endtask

   // monitor: compares every completed trap against the scoreboard
   always @(negedge clk) begin
      if (rst_n === 1'b1 && trap_done === 1'b1) begin
         if (exp_q.size() == 0) begin
            chk("R5", "unexpected trap_done", 64'd1, 64'd0);
         end else begin
            exp_t x;
            x = exp_q.pop_front();
            chk(x.req, "handler_pc", handler_pc, x.hpc);
            chk("R9", "trap_class", 64'(trap_class), 64'(x.cls));
            chk(x.req, "priv_mode", 64'(priv_mode), 64'(x.mode));
         end
      end
   end

   initial begin
      #2_000_000;
      chk("R11", "watchdog expired", 64'd1, 64'd0);
      finish_run();
   end

   initial begin
      rst_n = 1'b0; exc_valid = 1'b0; exc_kind = '0; exc_pc = '0; exc_info = '0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      m_mode = 2'd3; m_stat = '0; m_deleg = '0;
      for (int i = 0; i < 2; i++) begin
         m_vec[i] = '0; m_epc[i] = '0; m_cause[i] = '0; m_tval[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state
      chk("R11", "priv after reset", 64'(priv_mode), 64'd3);
      chk("R11", "trap_done after reset", 64'(trap_done), 64'd0);
      chk("R11", "req_err after reset", 64'(req_err), 64'd0);
      rd_chk("R11", 12'h300, 64'd0);
      rd_chk("R11", 12'h302, 64'd0);
      rd_chk("R11", 12'h343, 64'd0);

      // vectors, delegation mask with bit 11 masked (R13)
      sw_write(12'h305, 64'h0000_0000_8000_0001);
      sw_write(12'h105, 64'h0000_0000_4000_0003);
      sw_write(12'h302, 64'hFFFF);
      rd_chk("R13", 12'h302, 64'hF7FF);
      rd_chk("R11", 12'h305, 64'h8000_0001);

      // ecall from M with MIE set: machine level, MPP=3 (R1 R7 R8 R13)
      sw_write(12'h300, 64'h8);
      do_trap("R7", 4'd10, 64'h1000, 64'h55);
      chk_level("R8", 1);
      rd_chk("R1", 12'h342, 64'd11);

      // load access fault from U, delegated (R2 R3 R5 R6)
      sw_write(12'h7C0, 64'd0);
      sw_write(12'h300, 64'h2);
      do_trap("R5", 4'd5, 64'h2000, 64'h0);
      chk_level("R6", 0);
      rd_chk("R2", 12'h141, 64'h2004);

      // instruction page fault from S, odd PC, delegated (R2 R3 R6)
      do_trap("R4", 4'd11, 64'h3003, 64'hDEAD_BEEF);
      chk_level("R3", 0);
      rd_chk("R5", 12'h141, 64'h3002);

      // illegal from S, no delegation, PC wraps (R2 R3 R8)
      sw_write(12'h302, 64'h0);
      do_trap("R4", 4'd2, 64'hFFFF_FFFF_FFFF_FFFC, 64'h1234);
      chk_level("R2", 1);

      // bad kind rejected (R10)
      @(negedge clk);
      exc_valid = 1'b1; exc_kind = 4'd14; exc_pc = 64'h9000;
      @(negedge clk);
      exc_valid = 1'b0;
      chk("R10", "req_err after kind 14", 64'(req_err), 64'd1);
      chk("R10", "no trap_done after kind 14", 64'(trap_done), 64'd0);
      chk_level("R10", 1);

      // reserved privilege write rejected (R10)
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 12'h7C0; wr_data = 64'd2;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R10", "req_err after priv 2", 64'(req_err), 64'd1);
      rd_chk("R10", 12'h7C0, 64'(m_mode));

      // trap and software write in the same cycle (R12)
      do_trap("R12", 4'd3, 64'h5000, 64'h0, 1'b1, 12'h302, 64'hFFFF);
      rd_chk("R12", 12'h302, 64'h0);
      do_trap("R12", 4'd7, 64'h6000, 64'h0, 1'b1, 12'h343, 64'hAAAA);
      rd_chk("R12", 12'h343, 64'h6004);
      chk_level("R3", 1);

      // ecall from U delegated; store misaligned from U not delegated (R4 R8)
      sw_write(12'h302, 64'h0100);
      sw_write(12'h7C0, 64'd0);
      do_trap("R4", 4'd8, 64'h7000, 64'h77);
      chk_level("R3", 0);
      sw_write(12'h7C0, 64'd0);
      do_trap("R4", 4'd6, 64'h8000, 64'h0);
      chk_level("R8", 1);
      do_trap("R1", 4'd13, 64'h8800, 64'hCAFE);
      rd_chk("R1", 12'h342, 64'd15);

      repeat (2) @(negedge clk);
      chk("R5", "scoreboard drained", 64'(exp_q.size()), 64'd0);
      finish_run();
   end

endmodule